// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This block watches 32 general-purpose pins and raises one interrupt request per group of eight pins. Each pin is synchronised to the clock. The block compares each synchronised value with the value from the previous cycle. A difference in either direction on a pin that the group's mask admits sets that group's sticky flag. The unit does not report which pin changed, and no edge polarity can be selected.

The pins are observed regardless of who drives them. Software can therefore toggle a pin it drives as an output and so raise an interrupt on purpose.

A small register port holds the configuration:

- four 8-bit mask registers, one per group;
- a group enable register;
- a flag register that is cleared by writing 1 to a bit.

Each group's request is its flag gated by its enable bit.

Top module: `pinchg_irq`

## Requirements
- R1: Pin bits 8g+7 down to 8g belong to group g (g = 0..3). A change on one of them can only affect flag bit g and request bit g.
- R2: Mask register g is at address g (addresses 0 to 3). Its bit b admits pin 8g+b. A change on a pin whose mask bit is 0 sets no flag.
- R3: A pin change in either direction (0 to 1 or 1 to 0) on an admitted pin sets flag g. The flag is readable, and the request can rise, after the third rising clock edge that follows the change: two synchroniser stages, then the flag register.
- R4: The flags are at address 5, in bits 3:0. They stay set until a write to address 5 with a 1 in that bit position. A 0 written to a bit leaves that flag unchanged.
- R5: When a clear and a new admitted change for the same group fall on the same clock edge, the flag stays set.
- R6: The group enable register is at address 4, in bits 3:0. Request bit g equals flag g AND enable bit g.
- R7: After reset, every mask, the enable register and every flag read 0, and no request is raised.
- R8: Writing a mask register never by itself creates an event. The previous-sample state tracks every pin, whether masked or not.
- R9: Bits 7:4 of addresses 4 and 5 read as 0. Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Observed pins, asynchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr (combinational) |
| grp_irq_o | output | 4 | Per-group interrupt requests |

## Verification

Register writes take effect at the next rising edge, and read data follows the address in the same cycle. A pin change applied between edges first shows in a flag and a request after the third edge that follows it.

The bench keeps a history queue of the pin values sampled at each edge. It derives each edge's event from the entries two and three edges old, and updates its model state at every rising edge. Each falling edge then compares the requests and the read data against that model, so every result is checked exactly in the cycle it is due.

// File: rtl/pinchg_irq.sv
module pinchg_irq #(
  parameter int GROUPS = 4,
  parameter int GW     = 8,
  parameter int SYNC   = 2,
  parameter int AW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] pin_i,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [GW-1:0]        cfg_wdata,
  output logic [GW-1:0]        cfg_rdata,
  output logic [GROUPS-1:0]    grp_irq_o
);
  localparam int NP = GROUPS * GW;
  localparam logic [AW-1:0] EN_ADDR   = AW'(GROUPS);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(GROUPS + 1);

  logic [SYNC-1:0][NP-1:0]   sync_q;
  logic [NP-1:0]             prev_q, chg;
  logic [GROUPS-1:0][GW-1:0] mask_q;
  logic [GROUPS-1:0]         en_q, flag_q, set_vec, clr_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign chg = sync_q[SYNC-1] ^ prev_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign set_vec[g] = |(chg[g*GW +: GW] & mask_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[g] <= '0;
      else if (cfg_we && cfg_addr == AW'(g)) mask_q[g] <= cfg_wdata;
    end
  end

  assign clr_vec = (cfg_we && cfg_addr == FLAG_ADDR) ? cfg_wdata[GROUPS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (cfg_we && cfg_addr == EN_ADDR) en_q <= cfg_wdata[GROUPS-1:0];
      flag_q <= (flag_q & ~clr_vec) | set_vec;
    end
  end

  assign grp_irq_o = flag_q & en_q;

  always_comb begin
    cfg_rdata = '0;
    for (int g = 0; g < GROUPS; g++)
      if (cfg_addr == AW'(g)) cfg_rdata = mask_q[g];
    if (cfg_addr == EN_ADDR)   cfg_rdata = GW'(en_q);
    if (cfg_addr == FLAG_ADDR) cfg_rdata = GW'(flag_q);
  end

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_vec)) == $past(flag_q & ~clr_vec)));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  // R2
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));

  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_irq_o & ~en_q) == '0);

  // R8
  mask_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
endmodule

// File: tb/pinchg_irq_tb.sv
module pinchg_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_i;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [3:0]  grp_irq_o;

  always #4 clk = ~clk;

  pinchg_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .grp_irq_o(grp_irq_o)
  );

  int checks = 0, errors = 0;
  string cur_req = "R7";
  bit done = 0;

  logic [31:0] hist[$];
  logic [7:0]  m_mask[4];
  logic [3:0]  m_en, m_flag;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{32'h0, 32'h0, 32'h0, 32'h0};
      foreach (m_mask[i]) m_mask[i] = 8'h0;
      m_en = 4'h0;
      m_flag = 4'h0;
    end else begin
      logic [31:0] ev;
      logic [3:0]  clr;
      hist.push_back(pin_i);
      ev = hist[hist.size()-3] ^ hist[hist.size()-4];
      void'(hist.pop_front());
      clr = (cfg_we && cfg_addr == 3'd5) ? cfg_wdata[3:0] : 4'h0;
      m_flag = m_flag & ~clr;
      for (int g = 0; g < 4; g++)
        if ((ev[g*8 +: 8] & m_mask[g]) != 8'h0) m_flag[g] = 1'b1;
      if (cfg_we && cfg_addr < 3'd4) m_mask[cfg_addr] = cfg_wdata;
      if (cfg_we && cfg_addr == 3'd4) m_en = cfg_wdata[3:0];
    end
  end

  function automatic logic [7:0] m_read(logic [2:0] a);
    if (a < 3'd4) return m_mask[a];
    if (a == 3'd4) return {4'h0, m_en};
    if (a == 3'd5) return {4'h0, m_flag};
    return 8'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      chk(cur_req, 32'(grp_irq_o), 32'(m_flag & m_en));
      chk(cur_req, 32'(cfg_rdata), 32'(m_read(cfg_addr)));
    end
    cfg_we = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    rst_n = 1'b0; pin_i = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: everything reads zero after reset
    for (int a = 0; a < 8; a++) begin
      cfg_addr = 3'(a);
      #1 chk("R7", 32'(cfg_rdata), 32'h0);
    end
    chk("R7", 32'(grp_irq_o), 32'h0);
    cur_req = "R7"; idle(2);

    // R6: enable all groups; R2: masks read back
    cur_req = "R6"; wr(3'd4, 8'hFF);
    cur_req = "R2"; wr(3'd0, 8'h01); wr(3'd1, 8'h80); wr(3'd2, 8'h00); wr(3'd3, 8'h3C);
    cfg_addr = 3'd5;

    // R3: rising toggle on pin 0, flag due after third edge
    cur_req = "R3"; pin_i[0] = 1'b1;
    cyc(); cyc(); chk("R3", 32'(grp_irq_o), 32'h0);
    cyc(); chk("R3", 32'(grp_irq_o), 32'h1);
    // R4: write 0 has no effect, write 1 clears
    cur_req = "R4"; wr(3'd5, 8'h00); chk("R4", 32'(cfg_rdata), 32'h1);
    wr(3'd5, 8'h01); cfg_addr = 3'd5; #1 chk("R4", 32'(cfg_rdata), 32'h0);
    // R3: falling toggle
    cur_req = "R3"; pin_i[0] = 1'b0; idle(3); chk("R3", 32'(grp_irq_o), 32'h1);
    wr(3'd5, 8'h0F); cfg_addr = 3'd5;

    // R2: masked pin in group 2 ignored
    cur_req = "R2"; pin_i[16] = 1'b1; idle(5); chk("R2", 32'(grp_irq_o), 32'h0);
    // R1: pin 15 only reaches group 1
    cur_req = "R1"; pin_i[15] = 1'b1; idle(4); chk("R1", 32'(grp_irq_o), 32'h2);
    pin_i[29] = 1'b1; idle(4); chk("R1", 32'(grp_irq_o), 32'hA);
    wr(3'd5, 8'h0F); cfg_addr = 3'd5;

    // R8: unmasking a pin that changed earlier makes no event
    cur_req = "R8"; wr(3'd2, 8'h01); idle(6); chk("R8", 32'(grp_irq_o), 32'h0);

    // R5: clear on the same edge as a new set
    cur_req = "R5"; pin_i[0] = 1'b1; cyc(); cyc();
    wr(3'd5, 8'h01); cfg_addr = 3'd5; #1 chk("R5", 32'(cfg_rdata), 32'h1);
    wr(3'd5, 8'h01);

    // R6: flag set but disabled gives no request
    cur_req = "R6"; wr(3'd4, 8'h00); pin_i[0] = 1'b0; idle(4);
    chk("R6", 32'(grp_irq_o), 32'h0); wr(3'd4, 8'h01); chk("R6", 32'(grp_irq_o), 32'h1);

    // R9: unused addresses ignored
    cur_req = "R9"; wr(3'd6, 8'hFF); wr(3'd7, 8'hFF); wr(3'd4, 8'hFF);
    cfg_addr = 3'd6; #1 chk("R9", 32'(cfg_rdata), 32'h0);
    cfg_addr = 3'd4; #1 chk("R9", 32'(cfg_rdata), 32'h0F);

    // mixed traffic compared with the model every cycle (R1 R2 R3 R4 R5 R6 R8)
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) pin_i = pin_i ^ (32'h1 << $urandom_range(31));
      cfg_addr = 3'($urandom_range(7));
      if ($urandom_range(5) == 0) begin
        cfg_we = 1'b1; cfg_wdata = 8'($urandom);
      end
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule